// File: doc/BRIEF.md
# Cycle Counter with Compare Interrupt

This block is a processor-side timer built around two 32-bit registers: a counter that moves forward by one on every pulse of a timebase enable, and a compare value. When a step brings the counter onto the compare value, the block latches a pending flag and drives one of eight interrupt lines high. A 3-bit routing field picks that line. Software acknowledges the interrupt only by writing the compare register, which is also how it arms the next deadline.

The timebase enable is a single-cycle strobe. In the intended system it pulses at 100 MHz, one pulse per 10 ns. A freeze bit in the control register stops the counter in place. While frozen, no match can fire, and clearing the bit resumes counting from the held value. All three registers sit on one address port with a combinational read path. Writes take effect on the next clock edge.

The pending flag appears in the control register when the parameter `PEND_FLAG_EN` is 1, which is the default. The interrupt line is driven in either setting.

Top module: `cnt_cmp_timer`

## Requirements
- R1: After reset, the counter, the compare register, the freeze bit, the routing field and the pending flag are all zero, and every `irq_o` line is low.
- R2: The counter advances by exactly one on each clock edge where `tick_i` is high, freeze is clear and no counter write is taking place. It holds when `tick_i` is low. Reading address 0 returns the counter.
- R3: While the freeze bit (control bit 0) is set, the counter holds and no match fires. Clearing the bit resumes counting from the held value.
- R4: A write to address 0 loads the written value into the counter. On that edge the write takes priority over a tick.
- R5: A write to address 1 sets the compare register. Reading address 1 returns it.
- R6: When a counted step makes the new counter value equal the compare value, the pending flag (control bit 4, read-only) reads 1 from the same edge on, so it is visible together with the new counter value.
- R7: While the flag is pending, `irq_o` is one-hot at the index given by the routing field (control bits 3:1). It is all-zero otherwise.
- R8: The pending flag and its interrupt line stay set while the counter moves past the compare value. Only a compare write clears them.
- R9: A compare write clears the pending flag and the interrupt. If a match occurs on the same edge, the write wins.
- R10: The counter wraps from 0xFFFFFFFF to 0 with no effect other than an ordinary compare check.
- R11: A match fires only on a counted step. A counter or compare write that makes the two registers equal does not fire, and equality held without a step does not fire again.
- R12: Address 3 reads as zero. Writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timebase enable, one counter step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select: 0 counter, 1 compare, 2 control, 3 unused |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 8 | Interrupt lines, one-hot at the routed index while pending |

## Verification
The assertions check these rules on every cycle: a counted step adds exactly one, the counter holds while frozen or without a tick, the interrupt lines stay one-hot and follow the pending flag and the routing field, the flag stays set until a compare write, a compare write clears it, and the flag can rise only on an edge where a counted step happened. Some behaviour cannot be seen from one cycle alone: that the match hits exactly at the compare value, that the counter wraps, that a same-edge write wins over a match, and that equality created by a write does not fire. Only the bench scenarios show these. The bench's reference model is compared against the read port and the interrupt lines on every clock.

// File: rtl/cnt_cmp_timer_pkg.sv
package cnt_cmp_timer_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_CMP   = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int CTRL_FREEZE_BIT = 0;
  localparam int CTRL_ROUTE_LSB  = 1;

endpackage

// File: rtl/cnt_cmp_timer_counter.sv
module cnt_cmp_timer_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             freeze_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] count_next_o,
  output logic             step_o
);

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] count_q;

  assign step_o       = tick_i && !freeze_i && !load_i;
  assign count_next_o = bump(count_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (load_i) count_q <= load_val_i;
    else if (step_o) count_q <= count_next_o;
  end

  assign count_o = count_q;

endmodule

// File: rtl/cnt_cmp_timer_match.sv
module cnt_cmp_timer_match #(
  parameter int CNT_W   = 32,
  parameter int ROUTE_W = 3,
  localparam int N_IRQ  = 1 << ROUTE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_i,
  input  logic [CNT_W-1:0]   count_next_i,
  input  logic [CNT_W-1:0]   cmp_i,
  input  logic               ack_i,
  input  logic [ROUTE_W-1:0] route_i,
  output logic               hit_o,
  output logic               pend_o,
  output logic [N_IRQ-1:0]   irq_o
);

  function automatic logic is_hit(input logic stp,
                                  input logic [CNT_W-1:0] nxt,
                                  input logic [CNT_W-1:0] cmp);
    return stp && (nxt == cmp);
  endfunction

  logic pend_q;

  assign hit_o = is_hit(step_i, count_next_i, cmp_i);

  always_ff @(posedge clk) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (ack_i) pend_q <= 1'b0;
    else if (hit_o) pend_q <= 1'b1;
  end

  assign pend_o = pend_q;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    assign irq_o[i] = pend_q && (route_i == ROUTE_W'(i));
  end

endmodule

// File: rtl/cnt_cmp_timer_regs.sv
module cnt_cmp_timer_regs
  import cnt_cmp_timer_pkg::*;
#(
  parameter int CNT_W        = 32,
  parameter int ROUTE_W      = 3,
  parameter bit PEND_FLAG_EN = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en_i,
  input  logic [1:0]         addr_i,
  input  logic [CNT_W-1:0]   wdata_i,
  input  logic [CNT_W-1:0]   count_i,
  input  logic               pend_i,
  output logic               cnt_wr_o,
  output logic               cmp_wr_o,
  output logic [CNT_W-1:0]   cmp_o,
  output logic               freeze_o,
  output logic [ROUTE_W-1:0] route_o,
  output logic [CNT_W-1:0]   rdata_o
);

  localparam int CTRL_W = ROUTE_W + 2;

  reg_sel_e sel;
  logic [CNT_W-1:0]   cmp_q;
  logic               freeze_q;
  logic [ROUTE_W-1:0] route_q;
  logic               ctrl_wr;
  logic [CTRL_W-1:0]  ctrl_view;

  assign sel      = reg_sel_e'(addr_i);
  assign cnt_wr_o = wr_en_i && (sel == SEL_COUNT);
  assign cmp_wr_o = wr_en_i && (sel == SEL_CMP);
  assign ctrl_wr  = wr_en_i && (sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q    <= '0;
      freeze_q <= 1'b0;
      route_q  <= '0;
    end else begin
      if (cmp_wr_o) cmp_q <= wdata_i;
      if (ctrl_wr) begin
        freeze_q <= wdata_i[CTRL_FREEZE_BIT];
        route_q  <= wdata_i[CTRL_ROUTE_LSB +: ROUTE_W];
      end
    end
  end

  assign ctrl_view = {pend_i & PEND_FLAG_EN, route_q, freeze_q};

  always_comb begin
    unique case (sel)
      SEL_COUNT: rdata_o = count_i;
      SEL_CMP:   rdata_o = cmp_q;
      SEL_CTRL:  rdata_o = CNT_W'(ctrl_view);
      default:   rdata_o = '0;
    endcase
  end

  assign cmp_o    = cmp_q;
  assign freeze_o = freeze_q;
  assign route_o  = route_q;

endmodule

// File: rtl/cnt_cmp_timer.sv
module cnt_cmp_timer #(
  parameter int CNT_W        = 32,
  parameter int ROUTE_W      = 3,
  parameter bit PEND_FLAG_EN = 1'b1,
  localparam int N_IRQ       = 1 << ROUTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [1:0]       addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  output logic [N_IRQ-1:0] irq_o
);

  logic [CNT_W-1:0]   count_q;
  logic [CNT_W-1:0]   count_next;
  logic [CNT_W-1:0]   cmp_q;
  logic               step;
  logic               hit;
  logic               pend_q;
  logic               cnt_wr;
  logic               cmp_wr;
  logic               freeze_q;
  logic [ROUTE_W-1:0] route_q;

  cnt_cmp_timer_regs #(
    .CNT_W(CNT_W), .ROUTE_W(ROUTE_W), .PEND_FLAG_EN(PEND_FLAG_EN)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .count_i(count_q), .pend_i(pend_q),
    .cnt_wr_o(cnt_wr), .cmp_wr_o(cmp_wr), .cmp_o(cmp_q),
    .freeze_o(freeze_q), .route_o(route_q), .rdata_o(rdata_o)
  );

  cnt_cmp_timer_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n),
    .tick_i(tick_i), .freeze_i(freeze_q),
    .load_i(cnt_wr), .load_val_i(wdata_i),
    .count_o(count_q), .count_next_o(count_next), .step_o(step)
  );

  cnt_cmp_timer_match #(.CNT_W(CNT_W), .ROUTE_W(ROUTE_W)) u_match (
    .clk(clk), .rst_n(rst_n),
    .step_i(step), .count_next_i(count_next), .cmp_i(cmp_q),
    .ack_i(cmp_wr), .route_i(route_q),
    .hit_o(hit), .pend_o(pend_q), .irq_o(irq_o)
  );

endmodule

// File: rtl/cnt_cmp_timer_chk.sv
module cnt_cmp_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int ROUTE_W = 3,
  localparam int N_IRQ  = 1 << ROUTE_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick_i,
  input logic               freeze_q,
  input logic               cnt_wr,
  input logic               cmp_wr,
  input logic [CNT_W-1:0]   count_q,
  input logic               pend_q,
  input logic [ROUTE_W-1:0] route_q,
  input logic [N_IRQ-1:0]   irq_o
);

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i && !freeze_q && !cnt_wr |=> count_q == $past(count_q) + CNT_W'(1));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i && !cnt_wr |=> $stable(count_q));

  p_freeze_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_q && !cnt_wr |=> $stable(count_q));

  p_irq_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_o));

  p_irq_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> irq_o == (N_IRQ'(1) << route_q));

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> irq_o == '0);

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !cmp_wr |=> pend_q);

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !pend_q);

  p_rise_on_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && !(tick_i && !freeze_q && !cnt_wr) |=> !pend_q);

endmodule

bind cnt_cmp_timer cnt_cmp_timer_chk #(.CNT_W(CNT_W), .ROUTE_W(ROUTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .freeze_q(freeze_q),
  .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .count_q(count_q), .pend_q(pend_q),
  .route_q(route_q), .irq_o(irq_o)
);

// File: tb/tb_cnt_cmp_timer.sv
module tb_cnt_cmp_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cnt_cmp_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // Behavioural reference state
  int unsigned m_cnt, m_cmp;
  bit          m_frz, m_pend;
  int          m_route;

  always @(posedge clk) begin
    int unsigned o_cnt, o_cmp;
    bit o_frz, o_pend, w_cnt, w_cmp, w_ctl;
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_frz = 0; m_pend = 0; m_route = 0;
    end else begin
      o_cnt = m_cnt; o_cmp = m_cmp; o_frz = m_frz; o_pend = m_pend;
      w_cnt = wr_en_i && addr_i == 2'd0;
      w_cmp = wr_en_i && addr_i == 2'd1;
      w_ctl = wr_en_i && addr_i == 2'd2;
      if (w_cnt) m_cnt = wdata_i;
      else if (tick_i && !o_frz) begin
        m_cnt = o_cnt + 1;
        if (m_cnt == o_cmp) m_pend = 1;
      end
      if (w_cmp) begin m_cmp = wdata_i; m_pend = 0; end
      if (w_ctl) begin m_frz = wdata_i[0]; m_route = int'(wdata_i[3:1]); end
      if (!w_cmp && !o_pend && m_pend == 1 && !(tick_i && !o_frz && !w_cnt))
        m_pend = 0;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_cnt;
      2'd1: return m_cmp;
      2'd2: return {27'd0, m_pend, 3'(m_route), m_frz};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [7:0] exp_irq();
    return m_pend ? (8'd1 << m_route) : 8'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compared on every clock (R2 R6 R7 reference model)
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      check("R7 model irq", {24'd0, irq_o}, {24'd0, exp_irq()});
      check("R2 model rdata", rdata_o, exp_rd(addr_i));
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    step(3);
    rst_n = 1'b1;
    step();
    model_on = 1'b1;

    // R1 reset state
    rd(2'd0, v); check("R1 count", v, 0);
    rd(2'd1, v); check("R1 compare", v, 0);
    rd(2'd2, v); check("R1 control", v, 0);
    check("R1 irq", {24'd0, irq_o}, 0);

    // R2 counting only on tick
    wr(2'd0, 32'd10);
    step(3);
    rd(2'd0, v); check("R2 hold without tick", v, 10);
    tick_i = 1; step(5); tick_i = 0;
    rd(2'd0, v); check("R2 five ticks", v, 15);

    // R4 write beats tick
    tick_i = 1; wr(2'd0, 32'h1234_0000); tick_i = 0;
    rd(2'd0, v); check("R4 load with tick", v, 32'h1234_0000);

    // R5 compare readback
    wr(2'd1, 32'h0000_0100);
    rd(2'd1, v); check("R5 compare", v, 32'h100);

    // R6 / R7 match on route 5
    wr(2'd2, 32'hA);
    wr(2'd0, 32'h0FD);
    tick_i = 1; step(2); tick_i = 0;
    check("R6 no early fire", {24'd0, irq_o}, 0);
    tick_i = 1; step(1); tick_i = 0;
    rd(2'd0, v); check("R6 count at compare", v, 32'h100);
    rd(2'd2, v); check("R6 pending bit", v, 32'h1A);
    check("R7 routed line 5", {24'd0, irq_o}, 32'h20);

    // R8 sticky past compare
    tick_i = 1; step(4); tick_i = 0;
    check("R8 still pending", {24'd0, irq_o}, 32'h20);
    wr(2'd2, 32'h4);
    check("R7 reroute to 2", {24'd0, irq_o}, 32'h04);

    // R9 compare write acks
    wr(2'd1, 32'h200);
    check("R9 ack clears irq", {24'd0, irq_o}, 0);
    rd(2'd2, v); check("R9 pending cleared", v, 32'h4);

    // R9 simultaneous match and compare write
    wr(2'd0, 32'h1FF);
    tick_i = 1; wr(2'd1, 32'h200); tick_i = 0;
    rd(2'd0, v); check("R9 count advanced", v, 32'h200);
    check("R9 write wins", {24'd0, irq_o}, 0);

    // R11 equality made by writes does not fire
    wr(2'd0, 32'h300); wr(2'd1, 32'h300);
    step(3);
    check("R11 no fire on write equality", {24'd0, irq_o}, 0);

    // R3 freeze
    wr(2'd0, 32'h3FE);
    wr(2'd2, 32'h1);
    wr(2'd1, 32'h3FF);
    tick_i = 1; step(6); tick_i = 0;
    rd(2'd0, v); check("R3 frozen count", v, 32'h3FE);
    check("R3 no fire while frozen", {24'd0, irq_o}, 0);
    wr(2'd2, 32'h0);
    tick_i = 1; step(1); tick_i = 0;
    rd(2'd0, v); check("R3 resume no jump", v, 32'h3FF);
    check("R3 fires after resume", {24'd0, irq_o}, 32'h01);
    step(4);
    check("R11 no refire while held", {24'd0, irq_o}, 32'h01);
    wr(2'd1, 32'h3FF);
    step(3);
    check("R11 equal held no refire", {24'd0, irq_o}, 0);

    // R10 wrap
    wr(2'd1, 32'h5);
    wr(2'd0, 32'hFFFF_FFFF);
    tick_i = 1; step(1); tick_i = 0;
    rd(2'd0, v); check("R10 wrap to zero", v, 0);
    check("R10 no side effect", {24'd0, irq_o}, 0);
    wr(2'd1, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    tick_i = 1; step(1); tick_i = 0;
    check("R10 wrap matches zero", {24'd0, irq_o}, 32'h01);
    wr(2'd1, 32'h0);

    // R12 unused address
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); check("R12 reads zero", v, 0);
    rd(2'd1, v); check("R12 compare untouched", v, 0);
    rd(2'd2, v); check("R12 control untouched", v, 0);

    // Mixed traffic against the model
    wr(2'd1, 32'h40);
    wr(2'd0, 32'h0);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      tick_i = ($urandom_range(0, 3) != 0);
      addr_i = 2'($urandom_range(0, 3));
      if (r < 3) begin
        wr_en_i = 1; addr_i = 2'd1;
        wdata_i = m_cnt + $urandom_range(1, 40);
      end else if (r < 5) begin
        wr_en_i = 1; addr_i = 2'd2;
        wdata_i = 32'($urandom_range(0, 15));
      end else if (r < 6) begin
        wr_en_i = 1; addr_i = 2'd0;
        wdata_i = m_cmp - $urandom_range(0, 10);
      end else wr_en_i = 0;
      step();
    end
    wr_en_i = 0; tick_i = 0;
    step(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule